// File: doc/BRIEF.md
# Transactional Footprint Conflict Detector

This block follows the memory footprint of a single hardware transaction and decides when the transaction has to be thrown away. While a transaction is open, each load the local core issues adds its cache line to a read set. Each store adds its cache line to a write set. A store's data is held elsewhere and is not released until commit. Addresses are compared at cache-line granularity, so the byte offset inside a line plays no part in recording or matching.

Other agents' accesses arrive on a snoop port. The conflict rule is asymmetric. A remote read is a conflict only when it touches a line the transaction has written. A remote write is a conflict when it touches any line the transaction has read or written. Each set holds a fixed number of lines, and recording a new line in a full set also ends the transaction.

When the transaction ends, the block emits one of two single-cycle pulses. A commit pulse tells the surrounding logic to publish the whole write set as one atomic step. An abort pulse, with a cause code, tells it to discard the buffered writes and fall back. Both sets are emptied when the transaction ends, and an in-transaction flag tells the core whether a transaction is open.

Top module: `txn_footprint_guard`

## Requirements
- R1: After reset, `in_txn`, `abort_pulse` and `commit_pulse` are 0 and `abort_code` is 0.
- R2: When `cmd_begin` is sampled while `in_txn` is 0, `in_txn` is 1 in the next cycle. A `cmd_begin` sampled while `in_txn` is 1 has no effect. `cmd_commit` and `cmd_abort` sampled while `in_txn` is 0 produce no pulse.
- R3: Two addresses belong to the same line when they agree in bits [ADDR_W-1:6]. With the default 64-byte lines, bits [5:0] are ignored both when lines are recorded and when they are matched.
- R4: A snoop read (`snp_rd_valid`) to a line in the write set aborts the transaction with code 3'b001. A snoop read to a line that is only in the read set does not abort.
- R5: A snoop write (`snp_wr_valid`) to a line in the read set or in the write set aborts the transaction with code 3'b010.
- R6: Each set holds SET_LINES lines (8 by default). A load or store whose line is not yet in its set, arriving while that set already holds 8 lines, aborts with code 3'b011. An access to a line already in a full set does not abort.
- R7: `cmd_abort` sampled during a transaction aborts it with code 3'b100.
- R8: When several abort causes occur in one cycle, the code follows the priority snoop-write conflict, then snoop-read conflict, then capacity, then explicit abort. Any abort cause in the same cycle as `cmd_commit` wins, and no commit pulse is produced.
- R9: `cmd_commit` sampled during a transaction with no abort cause produces `commit_pulse` in the next cycle.
- R10: Both sets are empty after a commit or an abort. A load or store sampled in the same cycle that ends the transaction is not recorded.
- R11: A sampled abort or commit produces a pulse lasting exactly one cycle, in the next cycle, and `in_txn` is 0 in that cycle. `abort_pulse` and `commit_pulse` are never both 1. `abort_code` is 0 whenever `abort_pulse` is 0.
- R12: Loads and stores sampled while `in_txn` is 0 are not recorded in either set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_begin | input | 1 | Open a transaction |
| cmd_commit | input | 1 | Request commit of the open transaction |
| cmd_abort | input | 1 | Request an explicit abort |
| ld_valid | input | 1 | Local transactional load present |
| ld_addr | input | ADDR_W | Local load address |
| st_valid | input | 1 | Local transactional store present |
| st_addr | input | ADDR_W | Local store address |
| snp_rd_valid | input | 1 | Remote read present |
| snp_rd_addr | input | ADDR_W | Remote read address |
| snp_wr_valid | input | 1 | Remote write present |
| snp_wr_addr | input | ADDR_W | Remote write address |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_code | output | 3 | Abort cause: 1 remote read, 2 remote write, 3 capacity, 4 explicit |
| commit_pulse | output | 1 | One-cycle atomic commit indication |
| in_txn | output | 1 | 1 while a transaction is open |

## Verification
The embedded assertions check the following on every cycle:
- the pulse shape, exclusivity and `in_txn` relation of R11;
- that a set is empty after it is cleared;
- that a full set does not grow;
- that a write conflict or a read conflict produces the code it should;
- that an abort cause beats a same-cycle commit;
- that an idle block stays idle without a begin.

What each set actually holds can only be seen through later snoops. So line aliasing, duplicate suppression, the capacity boundary, the dropping of accesses made while idle or in the ending cycle, and the clearing between transactions are shown by the bench's directed and random scenarios. In those scenarios a behavioural reference model is compared with the outputs on every clock.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

   typedef enum logic [2:0] {
      ABT_NONE   = 3'd0,
      ABT_RMT_RD = 3'd1,
      ABT_RMT_WR = 3'd2,
      ABT_FULL   = 3'd3,
      ABT_SW     = 3'd4
   } abort_cause_e;

endpackage

// File: rtl/tfg_line_set.sv
module tfg_line_set #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 26,
   parameter int N_PROBE = 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clr,
   input  logic                            ins_req,
   input  logic [TAG_W-1:0]                ins_tag,
   input  logic [N_PROBE-1:0][TAG_W-1:0]   probe_tag,
   output logic [N_PROBE-1:0]              probe_hit,
   output logic                            ins_hit,
   output logic                            full
);

   generate
      if (ENTRIES < 1) begin : g_bad_entries
         $error("tfg_line_set: ENTRIES must be at least 1");
      end
      if (N_PROBE < 1) begin : g_bad_probe
         $error("tfg_line_set: N_PROBE must be at least 1");
      end
   endgenerate

   logic [ENTRIES-1:0]             vld;
   logic [ENTRIES-1:0][TAG_W-1:0]  tags;
   logic [ENTRIES-1:0]             ins_match;
   logic [ENTRIES-1:0]             free_oh;
   logic                           do_ins;

   // lowest empty slot, one-hot
   assign free_oh = ~vld & (vld + ENTRIES'(1));
   assign full    = &vld;

   genvar gi, gp;
   generate
      for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
         assign ins_match[gi] = vld[gi] && (tags[gi] == ins_tag);
      end
      for (gp = 0; gp < N_PROBE; gp++) begin : g_probe
         logic [ENTRIES-1:0] pm;
         for (gi = 0; gi < ENTRIES; gi++) begin : g_cmp
            assign pm[gi] = vld[gi] && (tags[gi] == probe_tag[gp]);
         end
         assign probe_hit[gp] = |pm;
      end
   endgenerate

   assign ins_hit = |ins_match;
   assign do_ins  = ins_req && !ins_hit && !full && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= '0;
         tags <= '0;
      end else if (clr) begin
         vld <= '0;
      end else if (do_ins) begin
         vld <= vld | free_oh;
         for (int i = 0; i < ENTRIES; i++) begin
            if (free_oh[i]) tags[i] <= ins_tag;
         end
      end
   end

   // R10
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (vld == '0));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && full && !ins_hit && !clr) |=> (vld == $past(vld)));

   // R6
   dup_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && ins_hit && !clr) |=> (vld == $past(vld)));

endmodule

// File: rtl/tfg_txn_ctrl.sv
module tfg_txn_ctrl
   import tfg_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_begin,
   input  logic          cmd_commit,
   input  logic          cmd_abort,
   input  logic          rd_conf,
   input  logic          wr_conf,
   input  logic          cap_ovf,
   output logic          in_txn,
   output logic          abort_pulse,
   output abort_cause_e  abort_code,
   output logic          commit_pulse,
   output logic          end_now
);

   abort_cause_e cause;
   logic         quit_abort;
   logic         quit_commit;

   always_comb begin
      cause = ABT_NONE;
      if (in_txn) begin
         if (wr_conf)        cause = ABT_RMT_WR;
         else if (rd_conf)   cause = ABT_RMT_RD;
         else if (cap_ovf)   cause = ABT_FULL;
         else if (cmd_abort) cause = ABT_SW;
      end
   end

   assign quit_abort  = (cause != ABT_NONE);
   assign quit_commit = in_txn && !quit_abort && cmd_commit;
   assign end_now     = quit_abort || quit_commit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_txn       <= 1'b0;
         abort_pulse  <= 1'b0;
         abort_code   <= ABT_NONE;
         commit_pulse <= 1'b0;
      end else begin
         in_txn       <= in_txn ? !end_now : cmd_begin;
         abort_pulse  <= quit_abort;
         abort_code   <= cause;
         commit_pulse <= quit_commit;
      end
   end

   // R8
   commit_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_txn && cmd_commit && (rd_conf || wr_conf || cap_ovf || cmd_abort))
      |=> (abort_pulse && !commit_pulse));

   // R5
   wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_txn && wr_conf) |=> (abort_pulse && abort_code == ABT_RMT_WR));

   // R11
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(abort_pulse && commit_pulse));

   // R11
   pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_pulse || commit_pulse) |-> !in_txn);

   // R11
   code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !abort_pulse |-> (abort_code == ABT_NONE));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_txn && !cmd_begin) |=> (!in_txn && !abort_pulse && !commit_pulse));

endmodule

// File: rtl/txn_footprint_guard.sv
module txn_footprint_guard
   import tfg_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SET_LINES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_begin,
   input  logic              cmd_commit,
   input  logic              cmd_abort,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              snp_rd_valid,
   input  logic [ADDR_W-1:0] snp_rd_addr,
   input  logic              snp_wr_valid,
   input  logic [ADDR_W-1:0] snp_wr_addr,
   output logic              abort_pulse,
   output logic [2:0]        abort_code,
   output logic              commit_pulse,
   output logic              in_txn
);

   localparam int OFS_W = $clog2(LINE_BYTES);
   localparam int TAG_W = ADDR_W - OFS_W;

   generate
      if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 2) begin : g_bad_line
         $error("txn_footprint_guard: LINE_BYTES must be a power of two of at least 2");
      end
      if (OFS_W >= ADDR_W) begin : g_bad_addr
         $error("txn_footprint_guard: ADDR_W must exceed the line offset width");
      end
   endgenerate

   logic [TAG_W-1:0] ld_tag, st_tag, rd_tag, wr_tag;
   assign ld_tag = ld_addr[ADDR_W-1:OFS_W];
   assign st_tag = st_addr[ADDR_W-1:OFS_W];
   assign rd_tag = snp_rd_addr[ADDR_W-1:OFS_W];
   assign wr_tag = snp_wr_addr[ADDR_W-1:OFS_W];

   logic unused_ofs;
   assign unused_ofs = ^{ld_addr[OFS_W-1:0], st_addr[OFS_W-1:0],
                         snp_rd_addr[OFS_W-1:0], snp_wr_addr[OFS_W-1:0]};

   logic         end_now;
   logic         r_hit_ins, r_full, w_hit_ins, w_full;
   logic [0:0]   r_probe_hit;
   logic [1:0]   w_probe_hit;
   logic         rd_conf, wr_conf, cap_ovf;
   abort_cause_e code_e;

   tfg_line_set #(
      .ENTRIES (SET_LINES),
      .TAG_W   (TAG_W),
      .N_PROBE (1)
   ) u_rset (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (end_now),
      .ins_req   (ld_valid && in_txn),
      .ins_tag   (ld_tag),
      .probe_tag (wr_tag),
      .probe_hit (r_probe_hit),
      .ins_hit   (r_hit_ins),
      .full      (r_full)
   );

   tfg_line_set #(
      .ENTRIES (SET_LINES),
      .TAG_W   (TAG_W),
      .N_PROBE (2)
   ) u_wset (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (end_now),
      .ins_req   (st_valid && in_txn),
      .ins_tag   (st_tag),
      .probe_tag ({wr_tag, rd_tag}),
      .probe_hit (w_probe_hit),
      .ins_hit   (w_hit_ins),
      .full      (w_full)
   );

   assign rd_conf = snp_rd_valid && w_probe_hit[0];
   assign wr_conf = snp_wr_valid && (r_probe_hit[0] || w_probe_hit[1]);
   assign cap_ovf = (ld_valid && !r_hit_ins && r_full) ||
                    (st_valid && !w_hit_ins && w_full);

   tfg_txn_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_begin    (cmd_begin),
      .cmd_commit   (cmd_commit),
      .cmd_abort    (cmd_abort),
      .rd_conf      (rd_conf),
      .wr_conf      (wr_conf),
      .cap_ovf      (cap_ovf),
      .in_txn       (in_txn),
      .abort_pulse  (abort_pulse),
      .abort_code   (code_e),
      .commit_pulse (commit_pulse),
      .end_now      (end_now)
   );

   assign abort_code = code_e;

   // R4
   rd_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_txn && rd_conf && !wr_conf) |=> (abort_pulse && abort_code == 3'd1));

   // R6
   cap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_txn && cap_ovf && !rd_conf && !wr_conf) |=> (abort_pulse && abort_code == 3'd3));

endmodule

// File: tb/tb_txn_footprint_guard.sv
module tb_txn_footprint_guard;

   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_begin, cmd_commit, cmd_abort;
   logic ld_valid, st_valid, snp_rd_valid, snp_wr_valid;
   logic [AW-1:0] ld_addr, st_addr, snp_rd_addr, snp_wr_addr;
   logic abort_pulse, commit_pulse, in_txn;
   logic [2:0] abort_code;

   always #10 clk = ~clk;

   txn_footprint_guard dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_begin(cmd_begin), .cmd_commit(cmd_commit), .cmd_abort(cmd_abort),
      .ld_valid(ld_valid), .ld_addr(ld_addr),
      .st_valid(st_valid), .st_addr(st_addr),
      .snp_rd_valid(snp_rd_valid), .snp_rd_addr(snp_rd_addr),
      .snp_wr_valid(snp_wr_valid), .snp_wr_addr(snp_wr_addr),
      .abort_pulse(abort_pulse), .abort_code(abort_code),
      .commit_pulse(commit_pulse), .in_txn(in_txn)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    done = 0;
   string cur_req = "R1";

   // reference model state
   bit           m_in = 0, m_abort = 0, m_commit = 0;
   int           m_code = 0;
   int unsigned  rq[$];
   int unsigned  wq[$];

   function automatic int unsigned ln(int unsigned n, int unsigned ofs);
      return n * 64 + (ofs % 64);
   endfunction

   function automatic bit inq(ref int unsigned q[$], input int unsigned line);
      foreach (q[i]) if (q[i] == line) return 1;
      return 0;
   endfunction

   task automatic model_step();
      bit rc, wc, cap;
      int unsigned lld, lst;
      m_abort = 0; m_commit = 0; m_code = 0;
      if (!rst_n) begin
         m_in = 0; rq.delete(); wq.delete();
      end else if (!m_in) begin
         if (cmd_begin) m_in = 1;
      end else begin
         lld = ld_addr / 64;
         lst = st_addr / 64;
         rc  = snp_rd_valid && inq(wq, snp_rd_addr / 64);
         wc  = snp_wr_valid && (inq(rq, snp_wr_addr / 64) || inq(wq, snp_wr_addr / 64));
         cap = (ld_valid && !inq(rq, lld) && rq.size() >= 8) ||
               (st_valid && !inq(wq, lst) && wq.size() >= 8);
         if (wc) m_code = 2;
         else if (rc) m_code = 1;
         else if (cap) m_code = 3;
         else if (cmd_abort) m_code = 4;
         if (m_code != 0) begin
            m_abort = 1; m_in = 0; rq.delete(); wq.delete();
         end else if (cmd_commit) begin
            m_commit = 1; m_in = 0; rq.delete(); wq.delete();
         end else begin
            if (ld_valid && !inq(rq, lld)) rq.push_back(lld);
            if (st_valid && !inq(wq, lst)) wq.push_back(lst);
         end
      end
   endtask

   task automatic chk(string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s cycle %0d %s: got %0d expected %0d", cur_req, cyc, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      cyc++;
      chk("in_txn", int'(in_txn), int'(m_in));
      chk("abort_pulse", int'(abort_pulse), int'(m_abort));
      chk("abort_code", int'(abort_code), m_code);
      chk("commit_pulse", int'(commit_pulse), int'(m_commit));
   endtask

   task automatic idle();
      cmd_begin = 0; cmd_commit = 0; cmd_abort = 0;
      ld_valid = 0; st_valid = 0; snp_rd_valid = 0; snp_wr_valid = 0;
      ld_addr = 0; st_addr = 0; snp_rd_addr = 0; snp_wr_addr = 0;
   endtask

   task automatic do_begin();
      idle(); cmd_begin = 1; tick(); idle();
   endtask
   task automatic do_load(int unsigned a);
      idle(); ld_valid = 1; ld_addr = a; tick(); idle();
   endtask
   task automatic do_store(int unsigned a);
      idle(); st_valid = 1; st_addr = a; tick(); idle();
   endtask
   task automatic do_snrd(int unsigned a);
      idle(); snp_rd_valid = 1; snp_rd_addr = a; tick(); idle(); tick();
   endtask
   task automatic do_snwr(int unsigned a);
      idle(); snp_wr_valid = 1; snp_wr_addr = a; tick(); idle(); tick();
   endtask
   task automatic do_commit();
      idle(); cmd_commit = 1; tick(); idle(); tick();
   endtask
   task automatic do_abort();
      idle(); cmd_abort = 1; tick(); idle(); tick();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #3000000;
      cur_req = "watchdog";
      n_vec++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
   end

   initial begin
      idle();
      @(negedge clk);
      tick(); tick();
      rst_n = 1;
      // R1 reset state
      cur_req = "R1";
      tick(); tick();

      // R12 idle accesses not recorded, idle commands ignored
      cur_req = "R12";
      do_load(ln(3, 0)); do_store(ln(4, 0));
      cur_req = "R2";
      idle(); cmd_commit = 1; tick();
      idle(); cmd_abort = 1; tick(); idle(); tick();
      do_begin(); tick();
      cur_req = "R12";
      do_snwr(ln(3, 5)); do_snwr(ln(4, 0)); do_snrd(ln(4, 0));
      cur_req = "R2";
      do_begin(); tick();           // second begin ignored
      do_abort();                    // explicit, code 4

      // R3 offsets ignored
      cur_req = "R3";
      do_begin(); do_load(ln(5, 60)); do_snwr(ln(5, 0));
      do_begin(); do_store(ln(6, 1)); do_snrd(ln(6, 63));
      do_begin(); do_load(ln(7, 0)); do_snwr(ln(8, 0)); do_abort();

      // R4 read conflicts only with write set
      cur_req = "R4";
      do_begin(); do_store(ln(10, 0)); do_snrd(ln(10, 9));
      do_begin(); do_load(ln(11, 0)); do_snrd(ln(11, 0));
      cur_req = "R9";
      do_commit();

      // R5 write conflicts with either set
      cur_req = "R5";
      do_begin(); do_store(ln(12, 0)); do_snwr(ln(12, 33));
      do_begin(); do_load(ln(13, 0)); do_store(ln(14, 0)); do_snwr(ln(13, 2));

      // R6 capacity in both sets
      cur_req = "R6";
      do_begin();
      for (int i = 0; i < 8; i++) do_load(ln(20 + i, 0));
      do_load(ln(23, 7));
      do_load(ln(40, 0));
      tick();
      do_begin();
      for (int i = 0; i < 8; i++) do_store(ln(50 + i, i));
      do_store(ln(52, 0));
      do_store(ln(60, 0));
      tick();

      // R7 explicit abort
      cur_req = "R7";
      do_begin(); do_load(ln(1, 0)); do_abort();

      // R8 priority
      cur_req = "R8";
      do_begin(); do_store(ln(30, 0)); do_load(ln(31, 0));
      idle(); snp_rd_valid = 1; snp_rd_addr = ln(30, 0);
      snp_wr_valid = 1; snp_wr_addr = ln(31, 0); cmd_commit = 1; cmd_abort = 1;
      tick(); idle(); tick();
      do_begin(); do_store(ln(30, 0));
      idle(); snp_rd_valid = 1; snp_rd_addr = ln(30, 0); cmd_abort = 1; cmd_commit = 1;
      tick(); idle(); tick();
      do_begin();
      for (int i = 0; i < 8; i++) do_load(ln(70 + i, 0));
      idle(); ld_valid = 1; ld_addr = ln(90, 0); cmd_abort = 1; cmd_commit = 1;
      tick(); idle(); tick();
      do_begin();
      idle(); cmd_abort = 1; cmd_commit = 1; tick(); idle(); tick();

      // R10 sets cleared; ending-cycle accesses dropped
      cur_req = "R10";
      do_begin(); do_load(ln(33, 0)); do_store(ln(34, 0)); do_commit();
      do_begin(); do_snwr(ln(33, 0)); do_snwr(ln(34, 0)); do_snrd(ln(34, 0));
      idle(); cmd_commit = 1; ld_valid = 1; ld_addr = ln(35, 0);
      st_valid = 1; st_addr = ln(36, 0); tick(); idle();
      do_begin(); do_snwr(ln(35, 0)); do_snwr(ln(36, 0)); do_commit();

      // R11 mixed random traffic against the model
      cur_req = "R11";
      for (int i = 0; i < 3000; i++) begin
         idle();
         cmd_begin    = ($urandom % 4) == 0;
         cmd_commit   = ($urandom % 24) == 0;
         cmd_abort    = ($urandom % 40) == 0;
         ld_valid     = ($urandom % 2) == 0;
         ld_addr      = $urandom % (12 * 64);
         st_valid     = ($urandom % 3) == 0;
         st_addr      = $urandom % (12 * 64);
         snp_rd_valid = ($urandom % 10) == 0;
         snp_rd_addr  = $urandom % (16 * 64);
         snp_wr_valid = ($urandom % 14) == 0;
         snp_wr_addr  = $urandom % (16 * 64);
         tick();
      end
      idle(); tick(); tick();
      summary();
   end

endmodule